// File: doc/BRIEF.md
# I2C Master SCL Waveform Generator

This block produces the serial clock of an I2C master from the peripheral clock. A byte engine sets one configuration word and raises an enable. The block then alternates SCL between a driven-low phase and a released-high phase. Each phase lasts a programmed divider value, shifted left by a power-of-two prescaler exponent, plus a fixed offset that is set per build.

For each falling edge the block produces a timing strobe for SDA. It comes a programmed hold count plus three clock cycles after the SCL falling edge, and tells the byte engine when it may change SDA. SCL is open-drain. The block reads the bus level back, and while another device holds the released SCL low, the high phase does not count (clock stretching). A phase ends only when the byte engine requests the next phase. Without that request the block keeps the current SCL level.

Top module: `scl_wave_gen`

## Requirements
- R1: While `en` is low (and after reset), `scl_drive_low` is 0 and `sda_upd_stb` stays 0. Dropping `en` during a low phase releases SCL one cycle later with an edge strobe. A pending SDA strobe is cancelled.
- R2: The first edge after `en` is sampled high (from low) drives SCL low in the next cycle, with `edge_stb`. Each low phase lasts `low_div * 2^exp + OFFSET` cycles. `low_div` is `cfg_word[7:0]` and `exp` is `cfg_word[18:16]`.
- R3: With SCL reading high, each high phase lasts `high_div * 2^exp + OFFSET` cycles, where `high_div` is `cfg_word[15:8]`.
- R4: `edge_stb` is high for exactly one cycle in the cycle where `scl_drive_low` takes a new value, and at no other time. This holds even with zero dividers, where a phase lasts OFFSET cycles.
- R5: An exponent field above EXP_MAX acts as EXP_MAX, with both dividers forced to 255. A field equal to EXP_MAX is used as written.
- R6: In a high phase, a cycle in which `scl_in` reads low is not counted, so a stretch of S cycles lengthens that phase by S.
- R7: `sda_upd_stb` pulses for one cycle `hold + 3` cycles after the cycle in which SCL is driven low. `hold` is `cfg_word[29:24]`.
- R8: A hold field above HOLD_MAX acts as HOLD_MAX.
- R9: When a phase count runs out while `step_req` is low, SCL keeps its level. It changes in the cycle after the first edge at which `step_req` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low releases SCL |
| cfg_word | input | 32 | Low divider [7:0], high divider [15:8], exponent [18:16], hold [29:24] |
| step_req | input | 1 | Byte engine allows the current phase to end |
| scl_in | input | 1 | Level read back from the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| edge_stb | output | 1 | One-cycle pulse at every SCL drive change |
| sda_upd_stb | output | 1 | One-cycle pulse when SDA may change |

## Verification
The generator runs with mid-range dividers and a nonzero exponent, which separates the low and high phase lengths. It runs with zero dividers, where only the offset sets the phase. It runs with exponents at and above the ceiling, which separates a true shift from saturation. A hold value above its ceiling shows clamping of the SDA delay, and a long low phase keeps that delay inside the phase. Other runs pull SCL low during a high phase, hold back the phase request, and drop the enable mid-phase. Each of these delays or cancels a known edge by a known number of cycles, so an edge that arrives a cycle early or late is caught against the expected timeline.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int CFG_W      = 32;
  localparam int DIV_W      = 8;
  localparam int EXP_FW     = 3;
  localparam int HOLD_FW    = 6;
  localparam int LO_LSB     = 0;
  localparam int HI_LSB     = 8;
  localparam int EXP_LSB    = 16;
  localparam int HOLD_LSB   = 24;
  localparam int HOLD_FIXED = 3;
  localparam int DIV_SAT    = 255;

  typedef struct packed {
    logic [HOLD_FW-1:0] hold;
    logic [EXP_FW-1:0]  expo;
    logic [DIV_W-1:0]   hi_div;
    logic [DIV_W-1:0]   lo_div;
  } scl_fields_t;

  function automatic scl_fields_t split_cfg(input logic [CFG_W-1:0] w);
    scl_fields_t f;
    f.lo_div = w[LO_LSB +: DIV_W];
    f.hi_div = w[HI_LSB +: DIV_W];
    f.expo   = w[EXP_LSB +: EXP_FW];
    f.hold   = w[HOLD_LSB +: HOLD_FW];
    return f;
  endfunction

  // cycles in one SCL phase: divider scaled by 2^e, plus fixed offset
  function automatic int unsigned phase_cycles(input int unsigned div,
                                               input int unsigned e,
                                               input int unsigned off);
    return (div << e) + off;
  endfunction

  // SDA delay after falling edge: clamped hold plus the fixed part
  function automatic int unsigned hold_cycles(input int unsigned h,
                                              input int unsigned hmax);
    return ((h > hmax) ? hmax : h) + HOLD_FIXED;
  endfunction
endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
  import scl_gen_pkg::*;
#(
  parameter int OFFSET   = 4,
  parameter int EXP_MAX  = 5,
  parameter int HOLD_MAX = 40,
  parameter int CNT_W    = 13,
  parameter int HCW      = 6
) (
  input  logic [CFG_W-1:0] cfg_word,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] high_len,
  output logic [HCW-1:0]   hold_len
);
  scl_fields_t f;
  logic        exp_over;
  int unsigned e_eff, lo_eff, hi_eff;
  logic        unused_cfg;

  assign unused_cfg = ^{cfg_word[CFG_W-1:HOLD_LSB+HOLD_FW],
                        cfg_word[HOLD_LSB-1:EXP_LSB+EXP_FW]};

  always_comb begin
    f        = split_cfg(cfg_word);
    exp_over = (int'(f.expo) > EXP_MAX);
    e_eff    = exp_over ? EXP_MAX : {29'd0, f.expo};
    lo_eff   = exp_over ? DIV_SAT : {24'd0, f.lo_div};
    hi_eff   = exp_over ? DIV_SAT : {24'd0, f.hi_div};
    low_len  = CNT_W'(phase_cycles(lo_eff, e_eff, OFFSET));
    high_len = CNT_W'(phase_cycles(hi_eff, e_eff, OFFSET));
    hold_len = HCW'(hold_cycles({26'd0, f.hold}, HOLD_MAX));
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step_req,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] high_len,
  output logic             scl_low,
  output logic             edge_stb,
  output logic             fall_go
);
  logic [CNT_W-1:0] cnt;
  logic             en_q;
  logic             start;
  logic             expire;
  logic             advance;

  assign start   = en & ~en_q;
  // a high phase may only end once the line really reads high
  assign expire  = (cnt == '0) & step_req & (scl_low | scl_in);
  assign advance = scl_low | scl_in;
  assign fall_go = en & (start | (expire & ~scl_low));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      scl_low  <= 1'b0;
      edge_stb <= 1'b0;
      cnt      <= '0;
    end else begin
      en_q <= en;
      if (!en) begin
        scl_low  <= 1'b0;
        edge_stb <= scl_low;
        cnt      <= '0;
      end else if (start) begin
        scl_low  <= 1'b1;
        edge_stb <= 1'b1;
        cnt      <= low_len - CNT_W'(1);
      end else if (expire) begin
        scl_low  <= ~scl_low;
        edge_stb <= 1'b1;
        cnt      <= scl_low ? (high_len - CNT_W'(1)) : (low_len - CNT_W'(1));
      end else begin
        edge_stb <= 1'b0;
        if (cnt != '0 && advance) cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/scl_hold_timer.sv
module scl_hold_timer #(
  parameter int HCW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           fall_go,
  input  logic [HCW-1:0] hold_len,
  output logic           sda_stb
);
  logic [HCW-1:0] hcnt;
  logic           active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt    <= '0;
      active  <= 1'b0;
      sda_stb <= 1'b0;
    end else if (!en) begin
      active  <= 1'b0;
      sda_stb <= 1'b0;
    end else if (fall_go) begin
      hcnt    <= hold_len;
      active  <= 1'b1;
      sda_stb <= 1'b0;
    end else if (active) begin
      sda_stb <= (hcnt == HCW'(1));
      if (hcnt == HCW'(1)) active <= 1'b0;
      hcnt <= hcnt - HCW'(1);
    end else begin
      sda_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/scl_wave_gen.sv
module scl_wave_gen
  import scl_gen_pkg::*;
#(
  parameter int OFFSET   = 4,
  parameter int EXP_MAX  = 5,
  parameter int HOLD_MAX = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             step_req,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             edge_stb,
  output logic             sda_upd_stb
);
  localparam int CNT_W = $clog2(DIV_SAT * (2 ** EXP_MAX) + OFFSET + 1);
  localparam int HCW   = $clog2(HOLD_MAX + HOLD_FIXED + 1);

  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] high_len;
  logic [HCW-1:0]   hold_len;
  logic             fall_go;

  scl_cfg_decode #(
    .OFFSET(OFFSET), .EXP_MAX(EXP_MAX), .HOLD_MAX(HOLD_MAX),
    .CNT_W(CNT_W), .HCW(HCW)
  ) i_decode (
    .cfg_word (cfg_word),
    .low_len  (low_len),
    .high_len (high_len),
    .hold_len (hold_len)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) i_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .step_req (step_req),
    .scl_in   (scl_in),
    .low_len  (low_len),
    .high_len (high_len),
    .scl_low  (scl_drive_low),
    .edge_stb (edge_stb),
    .fall_go  (fall_go)
  );

  scl_hold_timer #(.HCW(HCW)) i_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .fall_go  (fall_go),
    .hold_len (hold_len),
    .sda_stb  (sda_upd_stb)
  );
endmodule

// File: rtl/scl_wave_gen_chk.sv
module scl_wave_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic step_req,
  input logic scl_in,
  input logic scl_drive_low,
  input logic edge_stb,
  input logic sda_upd_stb,
  input logic fall_go
);
  a_r1_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !sda_upd_stb));

  a_r2_fall_start_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    fall_go |=> (scl_drive_low && edge_stb));

  a_r4_edge_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (edge_stb == (scl_drive_low != $past(scl_drive_low))));

  a_r6_stretch_holds_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !scl_drive_low && !scl_in) |=> !scl_drive_low);

  a_r7_sda_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sda_upd_stb |=> !sda_upd_stb);

  a_r9_waits_for_request: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && $past(en, 2) && !$past(step_req)) |-> $stable(scl_drive_low));
endmodule

bind scl_wave_gen scl_wave_gen_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en            (en),
  .step_req      (step_req),
  .scl_in        (scl_in),
  .scl_drive_low (scl_drive_low),
  .edge_stb      (edge_stb),
  .sda_upd_stb   (sda_upd_stb),
  .fall_go       (fall_go)
);

// File: tb/test_scl_wave_gen.sv
`timescale 1ns/1ps
module test_scl_wave_gen;
  localparam int OFFSET   = 4;
  localparam int EXP_MAX  = 5;
  localparam int HOLD_MAX = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        step_req = 1'b1;
  logic        stretch = 1'b0;
  logic [31:0] cfg = '0;
  logic        scl_drive_low, edge_stb, sda_upd_stb;
  logic        scl_in;

  assign scl_in = ~scl_drive_low & ~stretch;

  always #4 clk = ~clk;

  scl_wave_gen #(.OFFSET(OFFSET), .EXP_MAX(EXP_MAX), .HOLD_MAX(HOLD_MAX)) i_scl_wave_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_word(cfg), .step_req(step_req),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .edge_stb(edge_stb),
    .sda_upd_stb(sda_upd_stb)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0;
  int    fails = 0;
  int    q_kind[$];
  int    q_cyc[$];
  string q_tag[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // kinds: 0 = SCL driven low, 1 = SCL released, 2 = SDA update
  task automatic push(input int kind, input int at, input string tag);
    q_kind.push_back(kind);
    q_cyc.push_back(at);
    q_tag.push_back(tag);
  endtask

  task automatic got(input int kind);
    int ek, ec;
    string et;
    if (q_kind.size() == 0) begin
      check(1'b0, "R1", kind, -1);
    end else begin
      ek = q_kind.pop_front();
      ec = q_cyc.pop_front();
      et = q_tag.pop_front();
      check(ek == kind, et, kind, ek);
      check(ec == cyc, et, cyc, ec);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (edge_stb)    got(scl_drive_low ? 0 : 1);
      if (sda_upd_stb) got(2);
    end
  end

  function automatic int plen(input int div, input int e);
    if (e > EXP_MAX) return 255 * (1 << EXP_MAX) + OFFSET;
    return div * (1 << e) + OFFSET;
  endfunction

  function automatic int hlen(input int h);
    return ((h > HOLD_MAX) ? HOLD_MAX : h) + 3;
  endfunction

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic set_cfg(input int lo, input int hi, input int ex, input int hd);
    cfg = {2'b00, 6'(hd), 5'b00000, 3'(ex), 8'(hi), 8'(lo)};
  endtask

  task automatic run_case(input int lo, input int hi, input int ex, input int hd,
                          input int s, input int w,
                          input string t_lo, input string t_hi, input string t_hd);
    int l, h, d, f0, r0, f1, r1;
    l = plen(lo, ex);
    h = plen(hi, ex);
    d = hlen(hd);
    set_cfg(lo, hi, ex, hd);
    @(negedge clk);
    f0 = cyc + 1;
    r0 = f0 + l + w;
    f1 = r0 + h + s;
    r1 = f1 + l;
    push(0, f0, t_lo);
    push(2, f0 + d, t_hd);
    push(1, r0, (w > 0) ? "R9" : t_lo);
    push(0, f1, (s > 0) ? "R6" : t_hi);
    push(2, f1 + d, t_hd);
    push(1, r1, t_lo);
    en = 1'b1;
    step_req = (w == 0);
    if (w > 0) begin
      wait_cyc(f0 + l + w - 1);
      step_req = 1'b1;
    end
    if (s > 0) begin
      wait_cyc(r0);
      stretch = 1'b1;
      wait_cyc(r0 + s);
      stretch = 1'b0;
    end
    wait_cyc(r1 + 1);
    en = 1'b0;
    wait_cyc(r1 + 6);
    check(q_kind.size() == 0, t_lo, q_kind.size(), 0);
    check(scl_drive_low == 1'b0, "R1", scl_drive_low, 0);
  endtask

  task automatic drop_in_low();
    int f0;
    set_cfg(10, 1, 0, 2);
    @(negedge clk);
    f0 = cyc + 1;
    push(0, f0, "R2");
    push(1, f0 + 3, "R1");
    en = 1'b1;
    wait_cyc(f0 + 2);
    en = 1'b0;
    wait_cyc(f0 + 25);
    check(q_kind.size() == 0, "R1", q_kind.size(), 0);
    check(scl_drive_low == 1'b0, "R1", scl_drive_low, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(scl_drive_low == 1'b0, "R1", scl_drive_low, 0);
    check(edge_stb == 1'b0, "R1", edge_stb, 0);
    check(sda_upd_stb == 1'b0, "R1", sda_upd_stb, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_case(3, 5, 1, 2, 0, 0, "R2", "R3", "R7");     // L=10 H=14 D=5
    run_case(0, 0, 0, 0, 0, 0, "R4", "R4", "R7");     // L=4 H=4 D=3
    run_case(2, 1, 3, 10, 4, 3, "R2", "R3", "R7");    // L=20 H=12 D=13, stretch and wait
    run_case(1, 1, 7, 5, 0, 0, "R5", "R5", "R7");     // saturated: L=H=8164
    run_case(1, 2, 5, 4, 0, 0, "R5", "R5", "R7");     // at ceiling: L=36 H=68
    run_case(50, 3, 0, 63, 0, 0, "R2", "R3", "R8");   // hold clamps: D=43
    drop_in_low();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end
endmodule